// File: doc/BRIEF.md
# Converter Power-Mode Controller

This block decides when the conversion core and the reference of a serial converter are powered. It takes a two-bit power code from control-register writes, the falling and rising edges of chip select, and an end-of-conversion pulse. It drives two power enables and a flag that tells whether the most recent result was sampled with the core fully awake. Waking is timed by a counter of system clocks. The standby wake time and the shutdown wake time are separate parameters.

The two automatic modes power down after a good conversion and start waking on the next chip-select falling edge. The frame that triggers the wake-up is a dummy: its result is flagged invalid, and the core stays up so that the following frame gives a valid result. Full shutdown does not respond to chip-select falling edges. It is left only when a control write selects the normal code, and power-up then starts on the chip-select rising edge that closes that write's frame. A newly written code takes effect at the end of the conversion in which it was written. The configuration is held in every state.

Top module: `conv_power_ctrl`

## Requirements
- R1: After reset the controller is awake in normal mode: coreEn=1, refEn=1, resultValid=0.
- R2: Power code 2'b00 (normal) keeps coreEn=1 and refEn=1 across conversions.
- R3: Power code 2'b01 (auto standby): at the end of a valid conversion coreEn goes to 0 and refEn stays 1. A later csFall sets coreEn back to 1 in the next cycle.
- R4: Power code 2'b10 (auto shutdown): at the end of a valid conversion coreEn and refEn both go to 0. A later csFall sets both to 1 in the next cycle.
- R5: resultValid is updated only on convDone, and is held between conversions. It becomes 1 only if the frame's csFall was sampled after the wake timer had expired. The timer runs WAKE_STBY cycles after a standby wake and WAKE_SHDN cycles after a shutdown wake. A csFall in the same cycle as timer expiry counts as too early.
- R6: In an automatic mode, a conversion with an invalid result does not power down, so the core alternates between a dummy frame and a valid frame.
- R7: A code written with ctrlWrite is used at the next convDone, not before. A write in the same cycle as convDone counts for that conversion.
- R8: Power code 2'b11 (full shutdown) sets coreEn=0 and refEn=0. While in full shutdown, csFall and convDone are ignored and resultValid holds. A csRise powers up only if the last write in that state carried code 2'b00. Writes of other codes do not arm the wake-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWrite | input | 1 | One-cycle strobe: a control write carrying pmCode |
| pmCode | input | 2 | Power code of the control write |
| csFall | input | 1 | One-cycle pulse on chip-select falling edge (sampling edge) |
| csRise | input | 1 | One-cycle pulse on chip-select rising edge (frame end) |
| convDone | input | 1 | One-cycle pulse at the end of a conversion |
| coreEn | output | 1 | Conversion core power enable |
| refEn | output | 1 | Reference power enable |
| resultValid | output | 1 | Last conversion was sampled with the core fully awake |

## Verification
Two events can fall in the same cycle. The first pair is a control write and the end-of-conversion pulse; the bench drives both in one cycle while the core is awake in standby mode. It judges the outcome by the core staying powered and the result staying valid, which shows the new normal code was used for that very conversion. The second pair is timer expiry and a chip-select falling edge. The bench times a falling edge to land on the expiry cycle and expects an invalid result followed by no power-down.

// File: rtl/pwrctl_pkg.sv
package pwrctl_pkg;

  localparam logic [1:0] PM_NORMAL = 2'b00;
  localparam logic [1:0] PM_STBY   = 2'b01;
  localparam logic [1:0] PM_SHDN   = 2'b10;
  localparam logic [1:0] PM_FULL   = 2'b11;

  typedef enum logic [1:0] {
    PS_AWAKE  = 2'd0,
    PS_WAKING = 2'd1,
    PS_DOZE   = 2'd2,
    PS_OFF    = 2'd3
  } pwrState_t;

  // strobes from the control FSM to the timing datapath
  typedef struct packed {
    logic loadStby;  // start standby wake timer
    logic loadShdn;  // start shutdown wake timer
    logic sample;    // a sampling edge happened
    logic sampleOk;  // the core was fully awake at that edge
    logic commit;    // end of conversion: publish frame validity
  } pwrStrobe_t;

endpackage

// File: rtl/pwr_timer_dp.sv
module pwr_timer_dp
  import pwrctl_pkg::*;
#(
  parameter int WAKE_STBY = 20,
  parameter int WAKE_SHDN = 50
) (
  input  logic       clk,
  input  logic       rstN,
  input  pwrStrobe_t strb,
  output logic       timerDone,
  output logic       frameOk,
  output logic       resultValid
);

  localparam int WMAX = (WAKE_STBY > WAKE_SHDN) ? WAKE_STBY : WAKE_SHDN;
  localparam int TW   = $clog2(WMAX + 1);
  localparam logic [TW-1:0] LD_STBY = TW'(WAKE_STBY);
  localparam logic [TW-1:0] LD_SHDN = TW'(WAKE_SHDN);
  localparam logic [TW-1:0] ONE     = TW'(1);

  logic [TW-1:0] wakeCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wakeCnt <= '0;
    end else if (strb.loadStby) begin
      wakeCnt <= LD_STBY;
    end else if (strb.loadShdn) begin
      wakeCnt <= LD_SHDN;
    end else if (wakeCnt != '0) begin
      wakeCnt <= wakeCnt - ONE;
    end
  end

  assign timerDone = (wakeCnt == ONE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameOk     <= 1'b0;
      resultValid <= 1'b0;
    end else begin
      if (strb.sample) frameOk <= strb.sampleOk;
      if (strb.commit) resultValid <= frameOk;
    end
  end

  // R5: the result flag moves only at the end of a conversion
  a_r5_valid_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> $stable(resultValid));

  // R5: a freshly loaded timer is never already done
  a_r5_no_instant_done: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadStby || strb.loadShdn) |=> (wakeCnt != '0));

endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm
  import pwrctl_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctrlWrite,
  input  logic [1:0] pmCode,
  input  logic       csFall,
  input  logic       csRise,
  input  logic       convDone,
  input  logic       timerDone,
  input  logic       frameOk,
  output pwrStrobe_t strb,
  output logic       coreEn,
  output logic       refEn
);

  pwrState_t  st, nxtSt;
  logic [1:0] actCode, nxtAct;
  logic [1:0] pendCode, nxtPend;
  logic       wakeArmed, nxtArmed;
  logic [1:0] effCode;

  // a write in the same cycle as convDone belongs to that conversion
  assign effCode = ctrlWrite ? pmCode : pendCode;

  always_comb begin
    nxtSt    = st;
    nxtAct   = actCode;
    nxtPend  = effCode;
    nxtArmed = wakeArmed;
    strb     = '0;
    case (st)
      PS_OFF: begin
        if (ctrlWrite) nxtArmed = (pmCode == PM_NORMAL);
        if (csRise && (ctrlWrite ? (pmCode == PM_NORMAL) : wakeArmed)) begin
          nxtSt         = PS_WAKING;
          nxtAct        = PM_NORMAL;
          nxtPend       = PM_NORMAL;
          nxtArmed      = 1'b0;
          strb.loadShdn = 1'b1;
        end
      end
      PS_DOZE: begin
        if (csFall) begin
          nxtSt         = PS_WAKING;
          strb.sample   = 1'b1;
          strb.sampleOk = 1'b0;
          if (actCode == PM_STBY) strb.loadStby = 1'b1;
          else                    strb.loadShdn = 1'b1;
        end
      end
      default: begin
        if (csFall) begin
          strb.sample   = 1'b1;
          strb.sampleOk = (st == PS_AWAKE);
        end
        if (st == PS_WAKING && timerDone) nxtSt = PS_AWAKE;
        if (convDone) begin
          strb.commit = 1'b1;
          nxtAct      = effCode;
          if (effCode == PM_FULL) begin
            nxtSt    = PS_OFF;
            nxtArmed = 1'b0;
          end else if (effCode != PM_NORMAL && frameOk) begin
            nxtSt = PS_DOZE;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st        <= PS_AWAKE;
      actCode   <= PM_NORMAL;
      pendCode  <= PM_NORMAL;
      wakeArmed <= 1'b0;
    end else begin
      st        <= nxtSt;
      actCode   <= nxtAct;
      pendCode  <= nxtPend;
      wakeArmed <= nxtArmed;
    end
  end

  assign coreEn = (st == PS_AWAKE) || (st == PS_WAKING);
  assign refEn  = coreEn || ((st == PS_DOZE) && (actCode == PM_STBY));

  // R3: a sampling edge while dozing powers the core in the next cycle
  a_r3_wake_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    (st == PS_DOZE && csFall) |=> coreEn);

  // R5: the expiring wake timer brings the FSM to the awake state
  a_r5_timer_wakes: assert property (@(posedge clk) disable iff (!rstN)
    (st == PS_WAKING && timerDone && !convDone) |=> (st == PS_AWAKE));

  // R6: an invalid conversion never powers the core down in auto modes
  a_r6_dummy_keeps_power: assert property (@(posedge clk) disable iff (!rstN)
    (coreEn && convDone && !frameOk && effCode != PM_FULL) |=> coreEn);

  // R8: full shutdown only ends on a chip-select rising edge
  a_r8_full_stays: assert property (@(posedge clk) disable iff (!rstN)
    (st == PS_OFF && !csRise) |=> (st == PS_OFF && !coreEn && !refEn));

endmodule

// File: rtl/conv_power_ctrl.sv
module conv_power_ctrl
  import pwrctl_pkg::*;
#(
  parameter int WAKE_STBY = 20,
  parameter int WAKE_SHDN = 50
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctrlWrite,
  input  logic [1:0] pmCode,
  input  logic       csFall,
  input  logic       csRise,
  input  logic       convDone,
  output logic       coreEn,
  output logic       refEn,
  output logic       resultValid
);

  pwrStrobe_t strb;
  logic       timerDone;
  logic       frameOk;

  pwr_fsm u_fsm (
    .clk       (clk),
    .rstN      (rstN),
    .ctrlWrite (ctrlWrite),
    .pmCode    (pmCode),
    .csFall    (csFall),
    .csRise    (csRise),
    .convDone  (convDone),
    .timerDone (timerDone),
    .frameOk   (frameOk),
    .strb      (strb),
    .coreEn    (coreEn),
    .refEn     (refEn)
  );

  pwr_timer_dp #(
    .WAKE_STBY (WAKE_STBY),
    .WAKE_SHDN (WAKE_SHDN)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .timerDone   (timerDone),
    .frameOk     (frameOk),
    .resultValid (resultValid)
  );

endmodule

// File: tb/conv_power_ctrl_test.sv
module conv_power_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int STBY = 20;
  localparam int SHDN = 50;
  localparam int SETTLE = 60;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctrlWrite = 1'b0;
  logic [1:0] pmCode = 2'b00;
  logic csFall = 1'b0;
  logic csRise = 1'b0;
  logic convDone = 1'b0;
  logic coreEn, refEn, resultValid;

  int nChecks = 0;
  int nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  conv_power_ctrl #(.WAKE_STBY(STBY), .WAKE_SHDN(SHDN)) uut (
    .clk(clk), .rstN(rstN), .ctrlWrite(ctrlWrite), .pmCode(pmCode),
    .csFall(csFall), .csRise(csRise), .convDone(convDone),
    .coreEn(coreEn), .refEn(refEn), .resultValid(resultValid)
  );

  // {code, expected coreEn, expected refEn} after a valid frame writing code
  localparam logic [3:0] VEC [4] = '{
    {2'b00, 1'b1, 1'b1},
    {2'b01, 1'b0, 1'b1},
    {2'b10, 1'b0, 1'b0},
    {2'b11, 1'b0, 1'b0}
  };
  localparam string VREQ [4] = '{"R2", "R3", "R4", "R8"};

  task automatic chk(input string req, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pFall();
    csFall = 1'b1; @(negedge clk); csFall = 1'b0;
  endtask

  task automatic pRise();
    csRise = 1'b1; @(negedge clk); csRise = 1'b0;
  endtask

  task automatic pDone();
    convDone = 1'b1; @(negedge clk); convDone = 1'b0;
  endtask

  task automatic pWrite(input logic [1:0] c);
    ctrlWrite = 1'b1; pmCode = c; @(negedge clk); ctrlWrite = 1'b0;
  endtask

  task automatic pWriteDone(input logic [1:0] c);
    ctrlWrite = 1'b1; pmCode = c; convDone = 1'b1;
    @(negedge clk); ctrlWrite = 1'b0; convDone = 1'b0;
  endtask

  // one frame: sampling edge, optional write, conversion end, frame end
  task automatic frame(input logic doWrite, input logic [1:0] c);
    pFall(); idle(2);
    if (doWrite) pWrite(c);
    idle(2); pDone(); pRise(); idle(1);
  endtask

  // bring the block back to awake normal mode from any state
  task automatic restore();
    pFall(); idle(1); pWrite(2'b00); idle(1); pDone(); pRise(); idle(SETTLE);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nFail++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);
    // R1 reset state
    chk("R1 coreEn", coreEn, 1'b1);
    chk("R1 refEn", refEn, 1'b1);
    chk("R1 resultValid", resultValid, 1'b0);

    // table: a valid frame writing each code, then recovery to normal
    for (int i = 0; i < 4; i++) begin
      frame(1'b1, VEC[i][3:2]);
      chk({VREQ[i], " coreEn"}, coreEn, VEC[i][1]);
      chk({VREQ[i], " refEn"}, refEn, VEC[i][0]);
      chk({VREQ[i], " resultValid"}, resultValid, 1'b1);
      restore();
      chk("R8 recovered coreEn", coreEn, 1'b1);
      chk("R8 recovered refEn", refEn, 1'b1);
    end

    // R3/R5/R6: standby wake timing, expiry boundary and alternation
    frame(1'b1, 2'b01);
    chk("R3 doze coreEn", coreEn, 1'b0);
    pFall();
    chk("R3 wake coreEn", coreEn, 1'b1);
    idle(STBY - 1);
    pFall();                       // lands on the expiry cycle: too early
    idle(2); pDone();
    chk("R5 boundary resultValid", resultValid, 1'b0);
    chk("R6 dummy keeps coreEn", coreEn, 1'b1);
    pRise(); idle(2);
    frame(1'b0, 2'b00);
    chk("R5 awake resultValid", resultValid, 1'b1);
    chk("R6 valid frame dozes", coreEn, 1'b0);
    chk("R3 doze refEn", refEn, 1'b1);
    idle(5);
    chk("R5 resultValid held", resultValid, 1'b1);

    // R7: write and convDone in the same cycle
    pFall(); idle(1); pDone(); pRise();
    chk("R6 dummy resultValid", resultValid, 1'b0);
    idle(SETTLE);
    pFall(); idle(2); pWriteDone(2'b00); pRise(); idle(1);
    chk("R7 same-cycle write keeps coreEn", coreEn, 1'b1);
    chk("R7 same-cycle resultValid", resultValid, 1'b1);

    // R7: a write waits for the end of its conversion; R4 shutdown
    pFall(); idle(1); pWrite(2'b10); idle(3);
    chk("R7 before convDone coreEn", coreEn, 1'b1);
    chk("R7 before convDone refEn", refEn, 1'b1);
    pDone(); pRise(); idle(1);
    chk("R4 doze coreEn", coreEn, 1'b0);
    chk("R4 doze refEn", refEn, 1'b0);
    pFall();
    chk("R4 wake coreEn", coreEn, 1'b1);
    chk("R4 wake refEn", refEn, 1'b1);
    idle(STBY + 2);
    pDone(); pRise();
    chk("R5 shutdown wake longer than standby", resultValid, 1'b0);
    idle(SETTLE);

    // R8: full shutdown
    frame(1'b1, 2'b11);
    chk("R8 off coreEn", coreEn, 1'b0);
    chk("R8 off refEn", refEn, 1'b0);
    chk("R8 last result valid", resultValid, 1'b1);
    frame(1'b0, 2'b00);
    chk("R8 fall/done/rise ignored coreEn", coreEn, 1'b0);
    chk("R8 resultValid held", resultValid, 1'b1);
    pFall(); pWrite(2'b01); pRise(); idle(2);
    chk("R8 non-normal write does not arm", coreEn, 1'b0);
    pWrite(2'b00); idle(2); pRise();
    chk("R8 wake coreEn", coreEn, 1'b1);
    chk("R8 wake refEn", refEn, 1'b1);
    frame(1'b0, 2'b00);
    chk("R5 frame during shutdown wake invalid", resultValid, 1'b0);
    idle(SETTLE);
    frame(1'b0, 2'b00);
    chk("R5 frame after wake valid", resultValid, 1'b1);
    chk("R2 normal stays up", coreEn, 1'b1);

    summary();
    $finish;
  end

endmodule